// File: doc/BRIEF.md
# Power Island Switch Sequencer

This block is a hardware state machine that powers one switchable island up and down. Software issues on, off and error-clear commands by writing a single control word. A write is accepted only when its top byte holds the key value 0x5A. The sequencer drives the island's switch request, a two-bit inrush current limit, the electrical and functional isolation releases and the memory-repair request. It watches the island's power-good and repair-done indications, and both pass through two-flop synchronizers before the state machine uses them.

Power-up closes the switches at the weakest inrush limit. If power-good does not arrive within a bounded window, the limit is raised one level and the wait repeats. After power is good, the isolation and repair steps run in a fixed order. Each failure path unwinds what has already been applied, in reverse order, and sets a sticky error flag. Power-down releases nothing: it restores the two isolations and then opens the switches, one step per clock. A status word and three status pins report progress.

Top module: `pwr_island_seq`

## Requirements
- R1: A write (wr_en high) takes effect only when wr_data[31:24] equals 0x5A. A write with any other top byte changes no output and no status, and this includes the error-clear bit.
- R2: The command bits of an accepted write are: bit 8 starts power-up, bit 9 starts power-down, and bit 11 written as 1 clears the sticky error. When bits 8 and 9 are both set, bit 8 wins. An on or off command that arrives while busy_o is high is ignored.
- R3: Power-up raises pwr_req_o with inrush_o at 0. Each level waits PG_CYC cycles for synchronized power-good (750 cycles at the defaults: 250 MHz and 3 µs). If power-good has not arrived, inrush_o steps up by exactly one, through levels 0, 1, 2 and 3.
- R4: If power-good is still missing when the level-3 window ends, pwr_req_o and inrush_o are both cleared, err_o is set and done_o stays low.
- R5: Once power is good, iso_elec_rel_o rises first. repair_req_o rises on the next cycle. iso_func_rel_o rises only after synchronized repair-done, and done_o is set in the same cycle.
- R6: If repair-done does not arrive within MR_CYC cycles of the repair request (250 at the defaults), iso_elec_rel_o and repair_req_o drop first, which leaves repair_req_o high for 251 cycles. pwr_req_o and inrush_o then drop on the following cycle, and err_o is set.
- R7: A power-up command given while pwr_req_o is already high starts no sequence. busy_o stays low, the outputs keep their values and done_o reads 1.
- R8: Power-down clears iso_func_rel_o, then iso_elec_rel_o one cycle later, then pwr_req_o (together with repair_req_o) one cycle after that. It then sets done_o.
- R9: The power-good and repair-done inputs reach the state machine and the status word through two flops. A rise at the input appears in the status on the second clock edge after it.
- R10: The status word rd_data holds: [0] switch request, [1] synchronized power-good, [2] electrical isolation release, [3] repair request, [4] synchronized repair-done, [5] functional isolation release, [10] busy, [11] error, [12] done, [14:13] inrush level. All other bits are 0, and after reset the whole word is 0.
- R11: busy_o is high from the clock after an accepted on or off command until the sequence ends. done_o is cleared when such a sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control word: key in [31:24], commands in [11], [9] and [8] |
| rd_data | output | 32 | Status word |
| pgood_i | input | 1 | Power-good from the island (asynchronous) |
| rdone_i | input | 1 | Repair-done from the island (asynchronous) |
| pwr_req_o | output | 1 | Close the island's power switches |
| inrush_o | output | 2 | Inrush current limit level, 0 lowest |
| iso_elec_rel_o | output | 1 | Release electrical isolation |
| iso_func_rel_o | output | 1 | Release functional isolation |
| repair_req_o | output | 1 | Memory-repair request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence completed successfully |
| err_o | output | 1 | Sticky failure flag |

## Verification
The assertions assume that the island drops power-good and repair-done once their requests go away. They also assume that neither indication reaches the state machine in the middle of an unrelated state. The bench's island model follows this rule: it derives both signals from the block's own outputs, at the falling clock edge, after a random delay, and only the synchronizer check overrides power-good, and only while the island is switched off. Commands are given only after busy_o has fallen, except in the one case that deliberately sends an off command during a power-up. The random response delays stay below the timeout windows, so a sequence fails only when the island model is told never to answer.

// File: rtl/pwr_island_seq.sv
module pwr_island_seq #(
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned PG_WAIT_NS = 3000,
  parameter int unsigned MR_WAIT_NS = 1000,
  parameter logic [7:0]  KEY        = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        pgood_i,
  input  logic        rdone_i,
  output logic        pwr_req_o,
  output logic [1:0]  inrush_o,
  output logic        iso_elec_rel_o,
  output logic        iso_func_rel_o,
  output logic        repair_req_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int unsigned MHZ    = CLK_HZ / 1_000_000;
  localparam int unsigned PG_CYC = MHZ * PG_WAIT_NS / 1000;
  localparam int unsigned MR_CYC = MHZ * MR_WAIT_NS / 1000;
  localparam int unsigned MAXC   = (PG_CYC > MR_CYC) ? PG_CYC : MR_CYC;
  localparam int unsigned CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PG_LAST = CW'(PG_CYC - 1);
  localparam logic [CW-1:0] MR_LAST = CW'(MR_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RAMP, S_REPREQ, S_REPWAIT, S_UNISO, S_UNPWR, S_OFFF, S_OFFE, S_OFFP
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [1:0] pg_ff, md_ff;
  logic pwr_q, isoe_q, isof_q, rep_q, done_q, err_q;
  logic [1:0] inr_q;

  wire key_ok = wr_en && (wr_data[31:24] == KEY);
  wire pg_s = pg_ff[1];
  wire md_s = md_ff[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_ff <= '0;
      md_ff <= '0;
    end else begin
      pg_ff <= {pg_ff[0], pgood_i};
      md_ff <= {md_ff[0], rdone_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; inr_q <= '0;
      pwr_q <= 1'b0; isoe_q <= 1'b0; isof_q <= 1'b0; rep_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (key_ok && wr_data[11]) err_q <= 1'b0;
      case (st)
        S_IDLE:
          if (key_ok) begin
            if (wr_data[8]) begin
              if (pwr_q) done_q <= 1'b1;
              else begin
                done_q <= 1'b0; pwr_q <= 1'b1; inr_q <= 2'd0; cnt <= '0; st <= S_RAMP;
              end
            end else if (wr_data[9]) begin
              done_q <= 1'b0; st <= S_OFFF;
            end
          end
        S_RAMP:
          if (pg_s) begin
            isoe_q <= 1'b1; st <= S_REPREQ;
          end else if (cnt == PG_LAST) begin
            cnt <= '0;
            if (inr_q == 2'd3) st <= S_UNPWR;
            else inr_q <= inr_q + 2'd1;
          end else cnt <= cnt + 1'b1;
        S_REPREQ: begin
          rep_q <= 1'b1; cnt <= '0; st <= S_REPWAIT;
        end
        S_REPWAIT:
          if (md_s) begin
            isof_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
          end else if (cnt == MR_LAST) st <= S_UNISO;
          else cnt <= cnt + 1'b1;
        S_UNISO: begin
          isoe_q <= 1'b0; rep_q <= 1'b0; st <= S_UNPWR;
        end
        S_UNPWR: begin
          pwr_q <= 1'b0; inr_q <= 2'd0; err_q <= 1'b1; st <= S_IDLE;
        end
        S_OFFF: begin isof_q <= 1'b0; st <= S_OFFE; end
        S_OFFE: begin isoe_q <= 1'b0; st <= S_OFFP; end
        S_OFFP: begin
          pwr_q <= 1'b0; rep_q <= 1'b0; done_q <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end

  assign busy_o         = (st != S_IDLE);
  assign pwr_req_o      = pwr_q;
  assign inrush_o       = inr_q;
  assign iso_elec_rel_o = isoe_q;
  assign iso_func_rel_o = isof_q;
  assign repair_req_o   = rep_q;
  assign done_o         = done_q;
  assign err_o          = err_q;
  assign rd_data = {17'd0, inr_q, done_q, err_q, busy_o, 4'd0,
                    isof_q, md_s, rep_q, isoe_q, pg_s, pwr_q};

  assert_badkey_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && wr_en && wr_data[31:24] != KEY) |=> (st == S_IDLE && $stable(pwr_q)));

  assert_inrush_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inr_q) |-> (inr_q == $past(inr_q) + 2'd1 || inr_q == 2'd0));

  assert_err_without_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (!pwr_q && inr_q == 2'd0 && !done_q));

  assert_func_needs_elec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isof_q |-> (isoe_q && pwr_q && rep_q));

  assert_repair_needs_elec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q |-> (isoe_q || st == S_OFFP));

  assert_switch_opens_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_q) |-> (!isoe_q && !isof_q));
endmodule

// File: tb/tb_pwr_island_seq.sv
module tb_pwr_island_seq;
  localparam int PGW = 750;
  localparam int MRW = 250;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic pgood_i, rdone_i;
  logic pwr_req_o, iso_elec_rel_o, iso_func_rel_o, repair_req_o, busy_o, done_o, err_o;
  logic [1:0] inrush_o;

  pwr_island_seq dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  int need_lvl = 4, pg_dly = 5, md_dly = 5, pgc = 0, mdc = 0;
  bit md_ok = 1, ovr_en = 0, ovr_val = 0, pg_m = 0;
  always @(negedge clk) begin
    cyc++;
    if (pwr_req_o && int'(inrush_o) >= need_lvl) begin pgc++; pg_m = (pgc >= pg_dly); end
    else begin pgc = 0; pg_m = 0; end
    if (repair_req_o && md_ok) begin mdc++; rdone_i = (mdc >= md_dly); end
    else begin mdc = 0; rdone_i = 0; end
    pgood_i = ovr_en ? ovr_val : pg_m;
  end

  int lvl_cnt [4];
  int rep_cnt, t_isoe_r, t_rep_r, t_isof_r, t_isof_f, t_isoe_f, t_pwr_f;
  logic p_isoe = 0, p_rep = 0, p_isof = 0, p_pwr = 0;
  always @(negedge clk) begin
    if (pwr_req_o) lvl_cnt[inrush_o]++;
    if (repair_req_o) rep_cnt++;
    if (iso_elec_rel_o && !p_isoe) t_isoe_r = cyc;
    if (repair_req_o && !p_rep) t_rep_r = cyc;
    if (iso_func_rel_o && !p_isof) t_isof_r = cyc;
    if (!iso_func_rel_o && p_isof) t_isof_f = cyc;
    if (!iso_elec_rel_o && p_isoe) t_isoe_f = cyc;
    if (!pwr_req_o && p_pwr) t_pwr_f = cyc;
    p_isoe = iso_elec_rel_o; p_rep = repair_req_o; p_isof = iso_func_rel_o; p_pwr = pwr_req_o;
  end

  task automatic clr_mon();
    for (int i = 0; i < 4; i++) lvl_cnt[i] = 0;
    rep_cnt = 0; t_isoe_r = 0; t_rep_r = 0; t_isof_r = 0; t_isof_f = 0; t_isoe_f = 0; t_pwr_f = 0;
  endtask

  logic m_pwr = 0, m_isoe = 0, m_isof = 0, m_rep = 0, m_done = 0, m_err = 0;
  logic [1:0] m_inr = 0;

  function automatic logic [8:0] exp_vec();
    return {m_pwr, m_inr, m_isoe, m_isof, m_rep, 1'b0, m_done, m_err};
  endfunction

  function automatic logic [8:0] act_vec();
    return {pwr_req_o, inrush_o, iso_elec_rel_o, iso_func_rel_o, repair_req_o, busy_o, done_o, err_o};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] key, logic [23:0] low);
    @(negedge clk); wr_en = 1'b1; wr_data = {key, low};
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic model_on();
    if (m_pwr) begin m_done = 1; return; end
    if (need_lvl <= 3 && md_ok) begin
      m_pwr = 1; m_inr = 2'(need_lvl); m_isoe = 1; m_isof = 1; m_rep = 1; m_done = 1;
    end else begin
      m_pwr = 0; m_inr = 0; m_isoe = 0; m_isof = 0; m_rep = 0; m_done = 0; m_err = 1;
    end
  endtask

  task automatic model_off();
    m_pwr = 0; m_isoe = 0; m_isof = 0; m_rep = 0; m_done = 1;
  endtask

  task automatic run_on(string req);
    clr_mon(); wr(8'h5A, 24'h000100); wait_idle(); model_on();
    chk(req, 32'(act_vec()), 32'(exp_vec()));
  endtask

  task automatic run_off(string req);
    clr_mon(); wr(8'h5A, 24'h000200); wait_idle(); model_off();
    chk(req, 32'(act_vec()), 32'(exp_vec()));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = $urandom(32'd4711);
    pgood_i = 0; rdone_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset status", rd_data, 32'h0);
    chk("R11 reset outputs", 32'(act_vec()), 32'h0);

    wr(8'hA5, 24'h000100); repeat (4) @(negedge clk);
    chk("R1 bad key on", 32'(act_vec()), 32'h0);

    need_lvl = 4; md_ok = 1;
    run_on("R4 no power-good");
    chk("R3 level0 window", lvl_cnt[0], PGW);
    chk("R3 level1 window", lvl_cnt[1], PGW);
    chk("R3 level2 window", lvl_cnt[2], PGW);
    wr(8'h33, 24'h000800); repeat (2) @(negedge clk);
    chk("R1 bad key clear", err_o, 1);
    wr(8'h5A, 24'h000800); repeat (2) @(negedge clk); m_err = 0;
    chk("R2 error clear", err_o, 0);

    need_lvl = 2; pg_dly = 40; md_dly = 30;
    clr_mon(); wr(8'h5A, 24'h000100);
    chk("R11 busy after on", {busy_o, done_o}, 2'b10);
    wait_idle(); model_on();
    chk("R5 power-up result", 32'(act_vec()), 32'(exp_vec()));
    chk("R5 elec before repair", (t_isoe_r > 0 && t_rep_r == t_isoe_r + 1), 1);
    chk("R5 repair before func", (t_isof_r > t_rep_r), 1);
    chk("R10 status fields", rd_data, {17'd0, 2'd2, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1});

    clr_mon(); wr(8'h5A, 24'h000100);
    chk("R7 no busy when on", busy_o, 0);
    wait_idle(); model_on();
    chk("R7 already on", 32'(act_vec()), 32'(exp_vec()));

    run_off("R8 power-down result");
    chk("R8 elec after func", t_isoe_f - t_isof_f, 1);
    chk("R8 switch after elec", t_pwr_f - t_isoe_f, 1);

    need_lvl = 0; md_ok = 0;
    run_on("R6 repair timeout");
    chk("R6 repair window", rep_cnt, MRW + 1);
    chk("R6 power after isolation", t_pwr_f - t_isoe_f, 1);
    wr(8'h5A, 24'h000800); repeat (2) @(negedge clk); m_err = 0;

    need_lvl = 1; md_ok = 1; pg_dly = 100;
    clr_mon(); wr(8'h5A, 24'h000100);
    repeat (20) @(negedge clk);
    wr(8'h5A, 24'h000200);
    wait_idle(); model_on();
    chk("R2 off during busy ignored", 32'(act_vec()), 32'(exp_vec()));

    run_off("R8 off again");
    clr_mon(); wr(8'h5A, 24'h000300); wait_idle(); model_on();
    chk("R2 on wins over off", 32'(act_vec()), 32'(exp_vec()));
    run_off("R8 off third");

    @(negedge clk); ovr_en = 1; ovr_val = 1;
    @(negedge clk); chk("R9 one edge", rd_data[1], 0);
    @(negedge clk); chk("R9 two edges", rd_data[1], 1);
    ovr_en = 0; repeat (4) @(negedge clk);

    for (int it = 0; it < 30; it++) begin
      int op = $urandom_range(0, 9);
      need_lvl = $urandom_range(0, 7); if (need_lvl > 4) need_lvl = need_lvl - 4;
      md_ok = ($urandom_range(0, 9) != 0);
      pg_dly = $urandom_range(1, 300);
      md_dly = $urandom_range(1, 150);
      if (op < 6) run_on("R3 random on");
      else if (op < 9) run_off("R8 random off");
      else begin
        wr(8'h5A, 24'h000800); repeat (2) @(negedge clk); m_err = 0;
        chk("R2 random clear", 32'(act_vec()), 32'(exp_vec()));
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule